// File: doc/BRIEF.md
# Password-Gated Lock Override Unit

This unit sits next to a flash controller and keeps four groups of program/erase lock pages. Each group is guarded by its own 256-bit password, supplied as an input from non-volatile storage outside the unit. Software picks a group through a select register, then writes a 256-bit challenge as eight 32-bit words. Only when all eight words match the chosen group's password does that group's status bit set, and only then do its lock pages accept writes. A write to a page of a group still locked is dropped and flagged with a one-cycle error pulse.

Each lock page bit, 1 meaning locked, drives one effective lock output. Once the life-cycle stage input reaches the mature production stage, these outputs follow the lock pages. Below that stage they follow the flash controller's own lock bits. Lock pages take their reset value from a configuration input, and all written values are lost at reset.

Register map (word addresses): 0x00 group select, 0x01 unlocked status, 0x08 to 0x0F challenge words 0 to 7, 0x10 + 4*g + p lock page p of group g.

Top module: `pwlock_ovr`

## Requirements
- R1: Writing address 0x00 stores wdata[1:0] as the selected group (0 to 3). Reading 0x00 returns the selected group in bits [1:0].
- R2: Challenge word i is written at address 0x08+i. Word i is compared with bits [255-32i:224-32i] of the selected group's password, so word 0 carries the most significant 32 bits.
- R3: After the write that completes all eight challenge words since the last selection, status bit g (address 0x01, bit g for the selected group g) is set if all words match and cleared if any differ. It is visible one cycle after that write. An incomplete set of words never changes the status.
- R4: A write to the select register clears every status bit and discards any challenge words written so far.
- R5: Lock page p of group g sits at address 0x10+4g+p and takes a write only while status bit g is set. Reading it returns its contents, so writing 0xFFCF_FFFF to a page of all ones clears only bits 21 and 20.
- R6: A write to a lock page whose group's status bit is clear leaves the page unchanged. It raises err for exactly the cycle after the write. No other access raises err.
- R7: Reset loads lock page p of group g from rst_lock[(4g+p)*32 +: 32], clears all status bits, selects group 0, and drives rdata to 0 and eff_lock to all ones.
- R8: When lc_stage is 4 or above, eff_lock[(4g+p)*32 +: 32] equals lock page p of group g, one cycle later.
- R9: When lc_stage is below 4, eff_lock equals fc_lock, one cycle later.
- R10: rdata holds the read value in the cycle after rd_en and is 0 otherwise. Challenge addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | Rejected lock-page write, one cycle |
| pw_in | input | 1024 | Four 256-bit group passwords, group g at [g*256 +: 256] |
| rst_lock | input | 512 | Reset values of the sixteen lock pages |
| lc_stage | input | 3 | Device life-cycle stage |
| fc_lock | input | 512 | Flash controller's own lock bits |
| eff_lock | output | 512 | Effective lock bits, 1 = locked |

## Verification
Every result is due one clock after the input that causes it. This holds for rdata after a read, err after a rejected write, a status bit after the eighth challenge word, a page after its write, and eff_lock after a change in lc_stage or fc_lock. A lock-page write reaches eff_lock two clocks after the write. The bench drives inputs on the falling edge and updates a behavioural model on each rising edge. On the next falling edge it compares rdata, err and eff_lock with the model. Directed reads are sampled on the falling edge that follows the read strobe, so each check lands in the cycle its requirement names.

// File: rtl/pwlock_pkg.sv
package pwlock_pkg;
  localparam int A_SEL       = 0;
  localparam int A_STAT      = 1;
  localparam int A_CHAL_BASE = 8;
  localparam int A_LOCK_BASE = 16;
endpackage

// File: rtl/pwlock_chal.sv
module pwlock_chal #(
  parameter int NGRP = 4,
  parameter int PW_W = 256,
  parameter int CW   = 32,
  localparam int NW  = PW_W / CW,
  localparam int IW  = $clog2(NW),
  localparam int GW  = $clog2(NGRP)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_wr,
  input  logic [GW-1:0]        sel_val,
  input  logic                 chal_wr,
  input  logic [IW-1:0]        chal_idx,
  input  logic [CW-1:0]        wdata,
  input  logic [NGRP*PW_W-1:0] pw_in,
  output logic [GW-1:0]        sel_q,
  output logic [NGRP-1:0]      unl_q
);
  logic [NW-1:0]   seen_q, ok_q, seen_n, ok_n, onehot;
  logic [PW_W-1:0] pw_sel;
  logic [CW-1:0]   exp_word;
  logic            hit;

  always_comb begin
    pw_sel   = pw_in[int'(sel_q)*PW_W +: PW_W];
    exp_word = pw_sel[(NW-1-int'(chal_idx))*CW +: CW];
    hit      = (exp_word == wdata);
    onehot   = NW'(1) << chal_idx;
    seen_n   = seen_q | onehot;
    ok_n     = (ok_q & ~onehot) | (hit ? onehot : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      unl_q  <= '0;
      seen_q <= '0;
      ok_q   <= '0;
    end else if (sel_wr) begin
      sel_q  <= sel_val;
      unl_q  <= '0;
      seen_q <= '0;
      ok_q   <= '0;
    end else if (chal_wr) begin
      if (&seen_n) begin
        unl_q[sel_q] <= &ok_n;
        seen_q       <= '0;
        ok_q         <= '0;
      end else begin
        seen_q <= seen_n;
        ok_q   <= ok_n;
      end
    end
  end
endmodule

// File: rtl/pwlock_bank.sv
module pwlock_bank #(
  parameter int NGRP  = 4,
  parameter int NPAGE = 4,
  parameter int LW    = 32,
  localparam int GW   = $clog2(NGRP),
  localparam int PGW  = $clog2(NPAGE),
  localparam int NB   = NGRP * NPAGE * LW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NB-1:0]   rst_lock,
  input  logic            wr,
  input  logic [GW-1:0]   grp,
  input  logic [PGW-1:0]  page,
  input  logic [LW-1:0]   wdata,
  input  logic [NGRP-1:0] unl,
  output logic [NB-1:0]   lock_flat,
  output logic            err
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar p = 0; p < NPAGE; p++) begin : g_page
      localparam int OFS = (g * NPAGE + p) * LW;
      always_ff @(posedge clk) begin
        if (rst)
          lock_flat[OFS +: LW] <= rst_lock[OFS +: LW];
        else if (wr && unl[g] && int'(grp) == g && int'(page) == p)
          lock_flat[OFS +: LW] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= wr && !unl[grp];
  end
endmodule

// File: rtl/pwlock_out.sv
module pwlock_out #(
  parameter int NB     = 512,
  parameter int LCW    = 3,
  parameter int MATURE = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LCW-1:0] lc_stage,
  input  logic [NB-1:0]  lock_flat,
  input  logic [NB-1:0]  fc_lock,
  output logic [NB-1:0]  eff_lock
);
  always_ff @(posedge clk) begin
    if (rst)                            eff_lock <= '1;
    else if (lc_stage >= LCW'(MATURE))  eff_lock <= lock_flat;
    else                                eff_lock <= fc_lock;
  end
endmodule

// File: rtl/pwlock_ovr.sv
module pwlock_ovr #(
  parameter int NGRP   = 4,
  parameter int NPAGE  = 4,
  parameter int LW     = 32,
  parameter int PW_W   = 256,
  parameter int AW     = 6,
  parameter int LCW    = 3,
  parameter int MATURE = 4,
  localparam int NW    = PW_W / LW,
  localparam int IW    = $clog2(NW),
  localparam int GW    = $clog2(NGRP),
  localparam int PGW   = $clog2(NPAGE),
  localparam int NLP   = NGRP * NPAGE,
  localparam int NB    = NLP * LW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic [LW-1:0]        wdata,
  output logic [LW-1:0]        rdata,
  output logic                 err,
  input  logic [NGRP*PW_W-1:0] pw_in,
  input  logic [NB-1:0]        rst_lock,
  input  logic [LCW-1:0]       lc_stage,
  input  logic [NB-1:0]        fc_lock,
  output logic [NB-1:0]        eff_lock
);
  import pwlock_pkg::*;

  logic            is_sel, is_stat, is_chal, is_lock;
  logic [IW-1:0]   chal_idx;
  logic [AW-1:0]   lock_ofs;
  logic [GW-1:0]   sel_q;
  logic [NGRP-1:0] unl_q;
  logic [NB-1:0]   lock_flat;

  always_comb begin
    is_sel   = (int'(addr) == A_SEL);
    is_stat  = (int'(addr) == A_STAT);
    is_chal  = (int'(addr) >= A_CHAL_BASE) && (int'(addr) < A_CHAL_BASE + NW);
    is_lock  = (int'(addr) >= A_LOCK_BASE) && (int'(addr) < A_LOCK_BASE + NLP);
    chal_idx = IW'(int'(addr) - A_CHAL_BASE);
    lock_ofs = AW'(int'(addr) - A_LOCK_BASE);
  end

  pwlock_chal #(.NGRP(NGRP), .PW_W(PW_W), .CW(LW)) u_chal (
    .clk(clk), .rst(rst),
    .sel_wr(wr_en && is_sel), .sel_val(wdata[GW-1:0]),
    .chal_wr(wr_en && is_chal), .chal_idx(chal_idx),
    .wdata(wdata), .pw_in(pw_in),
    .sel_q(sel_q), .unl_q(unl_q)
  );

  pwlock_bank #(.NGRP(NGRP), .NPAGE(NPAGE), .LW(LW)) u_bank (
    .clk(clk), .rst(rst), .rst_lock(rst_lock),
    .wr(wr_en && is_lock),
    .grp(lock_ofs[PGW +: GW]), .page(lock_ofs[PGW-1:0]),
    .wdata(wdata), .unl(unl_q),
    .lock_flat(lock_flat), .err(err)
  );

  pwlock_out #(.NB(NB), .LCW(LCW), .MATURE(MATURE)) u_out (
    .clk(clk), .rst(rst), .lc_stage(lc_stage),
    .lock_flat(lock_flat), .fc_lock(fc_lock), .eff_lock(eff_lock)
  );

  always_ff @(posedge clk) begin
    if (rst || !rd_en)  rdata <= '0;
    else if (is_sel)    rdata <= LW'(sel_q);
    else if (is_stat)   rdata <= LW'(unl_q);
    else if (is_lock)   rdata <= lock_flat[int'(lock_ofs)*LW +: LW];
    else                rdata <= '0;
  end
endmodule

// File: rtl/pwlock_chk.sv
module pwlock_chk #(
  parameter int NGRP   = 4,
  parameter int NB     = 512,
  parameter int AW     = 6,
  parameter int LCW    = 3,
  parameter int MATURE = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic            err,
  input logic [NGRP-1:0] unl,
  input logic [NB-1:0]   lock_flat,
  input logic [LCW-1:0]  lc_stage,
  input logic [NB-1:0]   fc_lock,
  input logic [NB-1:0]   eff_lock
);
  AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    err |-> ($past(wr_en) && $past(addr) >= AW'(16))); // R6
  AST_SEL_CLEARS_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(addr) == AW'(0)) |-> (unl == '0)); // R4
  AST_UNLOCK_ON_CHALLENGE: assert property (@(posedge clk) disable iff (rst)
    ((unl & ~$past(unl)) != '0) |-> ($past(wr_en) && $past(addr) >= AW'(8) && $past(addr) < AW'(16))); // R3
  AST_PAGES_HELD_WHEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(unl) == '0) |-> $stable(lock_flat)); // R5
  AST_EFF_FOLLOWS_FLASH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lc_stage) < LCW'(MATURE)) |-> (eff_lock == $past(fc_lock))); // R9
  AST_EFF_FOLLOWS_PAGES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lc_stage) >= LCW'(MATURE)) |-> (eff_lock == $past(lock_flat))); // R8
endmodule

bind pwlock_ovr pwlock_chk #(.NGRP(NGRP), .NB(NB), .AW(AW), .LCW(LCW), .MATURE(MATURE)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .err(err), .unl(unl_q),
  .lock_flat(lock_flat), .lc_stage(lc_stage), .fc_lock(fc_lock), .eff_lock(eff_lock)
);

// File: tb/tb_pwlock_ovr.sv
`timescale 1ns/1ps
module tb_pwlock_ovr;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic err;
  logic [1023:0] pw_in;
  logic [511:0] rst_lock, fc_lock, eff_lock;
  logic [2:0] lc_stage = 3'd0;

  always #4 clk = ~clk;

  pwlock_ovr dut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err(err), .pw_in(pw_in), .rst_lock(rst_lock),
    .lc_stage(lc_stage), .fc_lock(fc_lock), .eff_lock(eff_lock));

  int n_chk = 0, n_bad = 0;
  logic [255:0] pw [4];
  logic [31:0] rv;

  initial begin
    for (int g = 0; g < 4; g++)
      for (int i = 0; i < 8; i++)
        pw[g][255-32*i -: 32] = 32'hC0DE_0000 ^ (g * 32'h0101_0000) ^ (i * 32'h0000_1357);
    for (int g = 0; g < 4; g++) pw_in[g*256 +: 256] = pw[g];
    rst_lock = '1;
    rst_lock[(4*3+2)*32 +: 32] = 32'h0000_FFFF;
    for (int k = 0; k < 16; k++) fc_lock[k*32 +: 32] = 32'h5A5A_0000 + k;
  end

  // behavioural reference model
  logic [31:0] m_lock [4][4];
  bit m_unl [4];
  int m_sel;
  logic [31:0] m_ch [8];
  bit m_seen [8];
  logic [31:0] x_rdata;
  logic x_err;
  logic [511:0] x_eff;
  bit started = 0;

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      for (int g = 0; g < 4; g++) begin
        m_unl[g] = 0;
        for (int p = 0; p < 4; p++) m_lock[g][p] = rst_lock[(4*g+p)*32 +: 32];
      end
      for (int i = 0; i < 8; i++) m_seen[i] = 0;
      m_sel = 0; x_rdata = 0; x_err = 0; x_eff = '1;
    end else begin
      for (int g = 0; g < 4; g++)
        for (int p = 0; p < 4; p++)
          x_eff[(4*g+p)*32 +: 32] = (lc_stage >= 3'd4) ? m_lock[g][p] : fc_lock[(4*g+p)*32 +: 32];
      x_err = 0; x_rdata = 0;
      if (rd_en) begin
        if (addr == 0) x_rdata = m_sel;
        else if (addr == 1) x_rdata = {28'd0, m_unl[3], m_unl[2], m_unl[1], m_unl[0]};
        else if (addr >= 16 && addr < 32) x_rdata = m_lock[(addr-16)/4][(addr-16)%4];
      end
      if (wr_en) begin
        if (addr == 0) begin
          m_sel = wdata[1:0];
          for (int g = 0; g < 4; g++) m_unl[g] = 0;
          for (int i = 0; i < 8; i++) m_seen[i] = 0;
        end else if (addr >= 8 && addr < 16) begin
          bit all;
          logic [255:0] cat;
          m_ch[addr-8] = wdata; m_seen[addr-8] = 1;
          all = 1;
          for (int i = 0; i < 8; i++) all = all & m_seen[i];
          if (all) begin
            cat = {m_ch[0], m_ch[1], m_ch[2], m_ch[3], m_ch[4], m_ch[5], m_ch[6], m_ch[7]};
            m_unl[m_sel] = (cat == pw[m_sel]);
            for (int i = 0; i < 8; i++) m_seen[i] = 0;
          end
        end else if (addr >= 16 && addr < 32) begin
          if (m_unl[(addr-16)/4]) m_lock[(addr-16)/4][(addr-16)%4] = wdata;
          else x_err = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      n_chk += 3;
      if (rdata !== x_rdata) begin
        n_bad++; $display("FAIL R10 rdata act=%h exp=%h", rdata, x_rdata);
      end
      if (err !== x_err) begin
        n_bad++; $display("FAIL R6 err act=%b exp=%b", err, x_err);
      end
      if (eff_lock !== x_eff) begin
        n_bad++;
        $display("FAIL %s eff_lock act=%h exp=%h", (lc_stage >= 4) ? "R8" : "R9", eff_lock, x_eff);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = 6'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); rd_en = 1; addr = 6'(a);
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic challenge(input int g, input int bad, input bit rev);
    wr(0, g);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      w = rev ? pw[g][255-32*(7-i) -: 32] : pw[g][255-32*i -: 32];
      if (i == bad) w = w ^ 32'h0000_0100;
      wr(8 + i, w);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    summary; $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    rd(16, rv);          chk("R7 g0p0 reset default", rv, 32'hFFFF_FFFF);
    rd(16 + 14, rv);     chk("R7 g3p2 configured default", rv, 32'h0000_FFFF);
    rd(1, rv);           chk("R7 status after reset", rv, 0);
    rd(0, rv);           chk("R7 select after reset", rv, 0);
    @(negedge clk);      chk("R9 premature uses flash lock", eff_lock[31:0], fc_lock[31:0]);

    wr(16, 32'h0);       chk("R6 err after locked write", {31'd0, err}, 1);
    rd(16, rv);          chk("R6 locked page unchanged", rv, 32'hFFFF_FFFF);

    wr(0, 2);
    rd(0, rv);           chk("R1 select readback", rv, 2);

    wr(0, 0);
    for (int i = 0; i < 7; i++) wr(8 + i, pw[0][255-32*i -: 32]);
    rd(1, rv);           chk("R3 partial does not unlock", rv, 0);
    wr(15, pw[0][31:0]);
    rd(1, rv);           chk("R3 full match unlocks group 0", rv, 32'h1);

    wr(16, 32'hFFCF_FFFF); chk("R6 no err when unlocked", {31'd0, err}, 0);
    rd(16, rv);          chk("R5 write clears bits 21 and 20", rv, 32'hFFCF_FFFF);
    lc_stage = 3'd4;
    @(negedge clk); @(negedge clk);
    chk("R8 mature uses lock page", eff_lock[31:0], 32'hFFCF_FFFF);

    wr(16 + 4, 32'h0);   chk("R6 other group still locked", {31'd0, err}, 1);
    rd(20, rv);          chk("R6 g1p0 unchanged", rv, 32'hFFFF_FFFF);

    wr(0, 1);
    rd(1, rv);           chk("R4 select clears status", rv, 0);
    rd(16, rv);          chk("R4 g0 page kept after select", rv, 32'hFFCF_FFFF);

    challenge(1, 5, 0);
    rd(1, rv);           chk("R3 mismatch stays locked", rv, 0);
    challenge(1, -1, 0);
    rd(1, rv);           chk("R3 group 1 unlocked", rv, 32'h2);
    wr(16 + 7, 32'h1234_5678);
    rd(16 + 7, rv);      chk("R5 g1p3 write", rv, 32'h1234_5678);
    challenge(1, 2, 0);
    rd(1, rv);           chk("R3 later mismatch relocks", rv, 0);

    challenge(2, -1, 1);
    rd(1, rv);           chk("R2 reversed word order rejected", rv, 0);

    wr(0, 2);
    for (int i = 0; i < 4; i++) wr(8 + i, pw[2][255-32*i -: 32]);
    wr(0, 2);
    for (int i = 4; i < 8; i++) wr(8 + i, pw[2][255-32*i -: 32]);
    rd(1, rv);           chk("R4 partial words discarded", rv, 0);
    challenge(2, -1, 0);
    rd(1, rv);           chk("R2 in-order group 2 unlocked", rv, 32'h4);

    rd(9, rv);           chk("R10 challenge reads zero", rv, 0);
    lc_stage = 3'd3;
    @(negedge clk); @(negedge clk);
    chk("R9 stage 3 uses flash lock", eff_lock[63:32], fc_lock[63:32]);

    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    rd(16, rv);          chk("R7 reset restores default", rv, 32'hFFFF_FFFF);
    rd(1, rv);           chk("R7 reset clears status", rv, 0);

    repeat (3) @(negedge clk);
    summary; $finish;
  end
endmodule